// File: doc/BRIEF.md
# Constant-Total Adaptive Symbol Histogram

This block keeps running frequency statistics for one narrow symbol channel (a few bits wide, so only a handful of bins) on behalf of an arithmetic coder. The sum of all bins never changes and is a power of two. A coder can therefore turn a count into a probability with a shift instead of a divide. Each accepted symbol adds one to its own bin. To keep the sum constant, one element is taken away from another bin, and that bin is chosen by a removal pointer.

The pointer walks the bins in a circle. On arriving at a bin it loads a weight of one quarter of that bin's count, and it then stays on that bin for that many further symbols. Busy bins therefore lose elements faster than quiet ones, which gives roughly the behaviour of forgetting the oldest symbols. The cost is two small registers instead of a history buffer. The coder reads the symbol's count and its cumulative count (the sum of all lower bins) in the same cycle the symbol is presented. The update takes effect at the following clock edge.

Top module: `rr_adaptive_hist`

## Requirements
- R1: After synchronous reset every bin holds TOTAL/NBINS (32 with defaults), and the removal pointer and the weight are both 0.
- R2: `sym_count` shows the current count of bin `sym`, and `sym_cum` shows the sum of the bins with a lower index. Both are combinational, use the pre-update values and are valid in the cycle `sym` is applied.
- R3: While `sym_valid` is low, no bin, pointer or weight changes.
- R4: On each accepted symbol, if the weight is 0 the pointer moves to the next bin (from NBINS-1 it wraps to 0) and the weight is loaded with the pre-update count of that new bin shifted right by 2. Otherwise the weight drops by 1 and the pointer stays where it is.
- R5: On each accepted symbol, bin `sym` gains 1 and the bin under the pointer after its step loses 1, both at the same clock edge.
- R6: If the bin under the stepped pointer holds exactly 1, neither the gain nor the loss takes place. The pointer step itself still happens.
- R7: When the symbol's bin is the removal bin, that bin's count is left unchanged.
- R8: The sum of all bins always equals TOTAL (256 with defaults), and no bin ever reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol accepted at the next clock edge |
| sym | input | SYM_W | Symbol value (bin index) |
| sym_count | output | CNT_W | Pre-update count of bin `sym` |
| sym_cum | output | CUM_W | Pre-update sum of bins below `sym` |

## Verification
A wrong pointer or weight does not show up at once. It moves the removal to the wrong bin, so a count differs from the expected value only when that bin is next read. That can be several symbols later, once the pointer lingers or wraps. A fault in the floor rule shows up after a long run of one symbol has drained the other bins, either as a zero count or as a total that drifts away from 256. For these reasons the bench keeps its own model of all bins, the pointer and the weight. It compares the count and cumulative value on every presented symbol, and it sweeps every bin while idle to expose errors in bins that are not being read.

// File: rtl/hist_pkg.sv
package hist_pkg;
  // Circular successor of a bin index.
  function automatic int unsigned next_bin(input int unsigned idx, input int unsigned nbins);
    return (idx == nbins - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/rr_remover.sv
module rr_remover #(
  parameter int NBINS = 8,
  parameter int CNT_W = 8,
  localparam int SYM_W = $clog2(NBINS)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        step,
  input  logic [NBINS-1:0][CNT_W-1:0] counts,
  output logic [SYM_W-1:0]            tgt,
  output logic [SYM_W-1:0]            ptr,
  output logic [CNT_W-1:0]            wt
);
  logic [CNT_W-1:0] wt_nxt;

  always_comb begin
    if (wt == '0) begin
      tgt    = SYM_W'(hist_pkg::next_bin(int'(ptr), NBINS));
      wt_nxt = counts[tgt] >> 2;
    end else begin
      tgt    = ptr;
      wt_nxt = wt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      wt  <= '0;
    end else if (step) begin
      ptr <= tgt;
      wt  <= wt_nxt;
    end
  end
endmodule

// File: rtl/bin_store.sv
module bin_store #(
  parameter int NBINS = 8,
  parameter int CNT_W = 8,
  parameter int TOTAL = 256,
  localparam int SYM_W = $clog2(NBINS),
  localparam int INIT  = TOTAL / NBINS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        upd,
  input  logic [SYM_W-1:0]            add_idx,
  input  logic [SYM_W-1:0]            sub_idx,
  output logic [NBINS-1:0][CNT_W-1:0] counts
);
  for (genvar i = 0; i < NBINS; i++) begin : g_bin
    logic inc, dec;
    assign inc = upd && (add_idx == SYM_W'(i)) && (sub_idx != SYM_W'(i));
    assign dec = upd && (sub_idx == SYM_W'(i)) && (add_idx != SYM_W'(i));
    always_ff @(posedge clk) begin
      if (rst)      counts[i] <= CNT_W'(INIT);
      else if (inc) counts[i] <= counts[i] + 1'b1;
      else if (dec) counts[i] <= counts[i] - 1'b1;
    end
  end
endmodule

// File: rtl/cum_select.sv
module cum_select #(
  parameter int NBINS = 8,
  parameter int CNT_W = 8,
  parameter int CUM_W = 9,
  localparam int SYM_W = $clog2(NBINS)
) (
  input  logic [NBINS-1:0][CNT_W-1:0] counts,
  input  logic [SYM_W-1:0]            sym,
  output logic [CNT_W-1:0]            sym_count,
  output logic [CUM_W-1:0]            sym_cum
);
  logic [CUM_W-1:0] prefix [NBINS+1];
  assign prefix[0] = '0;
  for (genvar i = 0; i < NBINS; i++) begin : g_pre
    assign prefix[i+1] = prefix[i] + CUM_W'(counts[i]);
  end
  assign sym_count = counts[sym];
  assign sym_cum   = prefix[sym];
endmodule

// File: rtl/rr_adaptive_hist.sv
module rr_adaptive_hist #(
  parameter int NBINS = 8,
  parameter int CNT_W = 8,
  parameter int TOTAL = 256,
  localparam int SYM_W = $clog2(NBINS),
  localparam int CUM_W = $clog2(TOTAL) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  input  logic [SYM_W-1:0] sym,
  output logic [CNT_W-1:0] sym_count,
  output logic [CUM_W-1:0] sym_cum
);
  logic [NBINS-1:0][CNT_W-1:0] counts;
  logic [SYM_W-1:0]            tgt, rm_ptr;
  logic [CNT_W-1:0]            rm_wt;
  logic                        upd;

  rr_remover #(.NBINS(NBINS), .CNT_W(CNT_W)) u_rem (
    .clk(clk), .rst(rst), .step(sym_valid), .counts(counts),
    .tgt(tgt), .ptr(rm_ptr), .wt(rm_wt)
  );

  // Floor rule: a bin holding one element is never drained.
  assign upd = sym_valid && (counts[tgt] != CNT_W'(1));

  bin_store #(.NBINS(NBINS), .CNT_W(CNT_W), .TOTAL(TOTAL)) u_bins (
    .clk(clk), .rst(rst), .upd(upd), .add_idx(sym), .sub_idx(tgt), .counts(counts)
  );

  cum_select #(.NBINS(NBINS), .CNT_W(CNT_W), .CUM_W(CUM_W)) u_cum (
    .counts(counts), .sym(sym), .sym_count(sym_count), .sym_cum(sym_cum)
  );
endmodule

// File: rtl/rr_adaptive_hist_chk.sv
module rr_adaptive_hist_chk #(
  parameter int NBINS = 8,
  parameter int CNT_W = 8,
  parameter int TOTAL = 256,
  localparam int SYM_W = $clog2(NBINS),
  localparam int CUM_W = $clog2(TOTAL) + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic [SYM_W-1:0] sym,
  input logic [CNT_W-1:0] sym_count,
  input logic [CUM_W-1:0] sym_cum,
  input logic [SYM_W-1:0] rm_ptr,
  input logic [CNT_W-1:0] rm_wt
);
  AST_TOTAL_CONST: assert property (@(posedge clk) disable iff (rst)
    (sym == SYM_W'(NBINS-1)) |-> (32'(sym_cum) + 32'(sym_count) == TOTAL)); // R8
  AST_BIN_FLOOR: assert property (@(posedge clk) disable iff (rst)
    sym_count != '0); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sym_valid |=> (sym != $past(sym)) || $stable(sym_count)); // R3
  AST_PTR_LINGER: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && rm_wt != '0) |=> $stable(rm_ptr)); // R4
  AST_WT_COUNTDOWN: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && rm_wt != '0) |=> rm_wt == $past(rm_wt) - 1'b1); // R4
  AST_PTR_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (sym_valid && rm_wt == '0) |=>
      rm_ptr == (($past(rm_ptr) == SYM_W'(NBINS-1)) ? '0 : $past(rm_ptr) + 1'b1)); // R4
endmodule

bind rr_adaptive_hist rr_adaptive_hist_chk #(.NBINS(NBINS), .CNT_W(CNT_W), .TOTAL(TOTAL)) i_chk (
  .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym), .sym_count(sym_count),
  .sym_cum(sym_cum), .rm_ptr(rm_ptr), .rm_wt(rm_wt)
);

// File: tb/test_rr_adaptive_hist.sv
module test_rr_adaptive_hist;
  localparam int NB = 8;
  localparam int TOT = 256;
  localparam int NT = 5;
  localparam int TBL_SYM [NT] = '{3, 3, 0, 1, 7};
  localparam int TBL_CNT [NT] = '{32, 33, 32, 29, 32};
  localparam int TBL_CUM [NT] = '{96, 95, 0, 33, 224};

  logic clk = 0, rst = 1, sym_valid = 0;
  logic [2:0] sym = '0;
  logic [7:0] sym_count;
  logic [8:0] sym_cum;
  int checks = 0, errors = 0;
  int mdl [NB];
  int mx, mk;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  rr_adaptive_hist i_rr_adaptive_hist (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym),
    .sym_count(sym_count), .sym_cum(sym_cum)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic mdl_reset();
    for (int i = 0; i < NB; i++) mdl[i] = TOT / NB;
    mx = 0; mk = 0;
  endtask

  function automatic int mdl_cum(input int s);
    int c = 0;
    for (int i = 0; i < s; i++) c += mdl[i];
    return c;
  endfunction

  task automatic mdl_step(input int s);
    if (mk == 0) begin
      mx = (mx == NB - 1) ? 0 : mx + 1;
      mk = mdl[mx] / 4;
    end else mk--;
    if (mdl[mx] != 1) begin
      mdl[s]++;
      mdl[mx]--;
    end
  endtask

  // Present a symbol between edges; outputs are read before the committing edge.
  task automatic apply(input bit v, input int s, input string req);
    @(negedge clk);
    sym_valid = v; sym = 3'(s);
    #1;
    chk(sym_count == 8'(mdl[s]), req, sym_count, mdl[s]);
    chk(sym_cum == 9'(mdl_cum(s)), req, sym_cum, mdl_cum(s));
    if (v) mdl_step(s);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; sym_valid = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    mdl_reset();
  endtask

  task automatic sweep(input string req);
    for (int s = 0; s < NB; s++) apply(0, s, req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state observed on every bin
    for (int s = 0; s < NB; s++) begin
      @(negedge clk); sym = 3'(s); #1;
      chk(sym_count == 8'd32, "R1 count", sym_count, 32);
      chk(sym_cum == 9'(32 * s), "R1 cum", sym_cum, 32 * s);
    end
    // Table of hand-derived vectors: R2 R4 R5
    for (int t = 0; t < NT; t++) begin
      @(negedge clk);
      sym_valid = 1; sym = 3'(TBL_SYM[t]); #1;
      chk(sym_count == 8'(TBL_CNT[t]), "R2 R5 table count", sym_count, TBL_CNT[t]);
      chk(sym_cum == 9'(TBL_CUM[t]), "R2 R4 table cum", sym_cum, TBL_CUM[t]);
      mdl_step(TBL_SYM[t]);
    end
    // R3: idle cycles change nothing
    sweep("R3 before idle");
    repeat (10) apply(0, 5, "R3 idle");
    sweep("R3 after idle");
    // R7: first step after reset removes from bin 1; add to bin 1 nets zero
    do_reset();
    apply(1, 1, "R7 apply");
    apply(0, 1, "R7 bin1 unchanged");
    chk(sym_count == 8'd32, "R7", sym_count, 32);
    // Pseudo-random stream vs model: R2 R4 R5 R8
    for (int n = 0; n < 800; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      apply(lfsr[0], int'(lfsr[3:1]), "R2 R4 R5 random");
    end
    sweep("R8 after random");
    apply(0, 7, "R8 total");
    chk(int'(sym_cum) + int'(sym_count) == TOT, "R8 total", int'(sym_cum) + int'(sym_count), TOT);
    // Drain all other bins with one symbol: R6 R8 floor
    do_reset();
    for (int n = 0; n < 1500; n++) apply(1, 0, "R6 drain");
    sweep("R6 floor sweep");
    for (int s = 1; s < NB; s++) begin
      apply(0, s, "R6 floor");
      chk(sym_count == 8'd1, "R6 bin at floor", sym_count, 1);
    end
    apply(0, 0, "R8 dominant");
    chk(sym_count == 8'(TOT - (NB - 1)), "R8 dominant bin", sym_count, TOT - (NB - 1));
    // Further symbols while drained keep the floor: R6
    for (int n = 0; n < 40; n++) apply(1, n % NB, "R6 drained stream");
    sweep("R6 R8 final sweep");
    // Reset mid-run restores R1
    do_reset();
    sweep("R1 after rerun reset");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule